// File: doc/BRIEF.md
# Consecutive-Ones Run Counter

This block walks a fixed window of 64 bytes, from byte address 32 to byte address 95, in a single-port synchronous data RAM. For every byte it decides whether the byte holds four or more adjacent 1 bits. The run may begin at any bit position. It then stores the number of such bytes as one byte at address 5.

A controller pulses `start` while the block is idle. The block then drives the RAM port by itself. It issues one read per cycle and a single write at the end, and it never issues a read and a write in the same cycle. When the write is complete it raises `done` for one cycle.

The RAM interface has no handshake. A read issued in one cycle returns its data on `mem_rdata` in the next cycle, and the RAM must always accept the access. There is therefore no back-pressure on this port, and the scan always takes the same number of cycles.

Top module: `ones_run_counter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: After `start` is accepted, the block reads addresses 32 through 95 in ascending order. It makes one read per cycle in 64 consecutive cycles, and reads each address exactly once.
- R3: A byte qualifies when at least four adjacent bits are 1, at any position. Examples that qualify: 10111101, 01111101, 11111111, 00011110. Examples that do not qualify: 10110011, 10100010, 11101110, 11100111, 01110111.
- R4: The value written is the number of qualifying bytes in the window, from 0 to 64, zero-extended to 8 bits. The count restarts from zero on every accepted `start`. It does not depend on any earlier run or on any earlier memory contents.
- R5: `mem_rd_en` and `mem_wr_en` are never high in the same cycle.
- R6: Each run makes exactly one write, to address 5. No other address is ever written.
- R7: `done` is high for exactly one cycle, in the cycle after the result write. This is 66 cycles (the window length plus 2) after the clock edge that accepts `start`.
- R8: `busy` is high from the edge that accepts `start` until the result write is complete. A `start` pulse while `busy` is high has no effect on the addresses read, the value written, or the timing of `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan; accepted only while idle |
| busy | output | 1 | High while a scan or the result write is in progress |
| done | output | 1 | One-cycle pulse after the result write |
| mem_addr | output | 8 | RAM byte address |
| mem_rd_en | output | 1 | Read request; data returns the next cycle |
| mem_wr_en | output | 1 | Write request |
| mem_wdata | output | 8 | Write data (the count) |
| mem_rdata | input | 8 | Read data, one cycle after the request |

## Verification
The main tests fill the window in three bands of 22, 21 and 21 bytes and check the stored count. Each band mix is chosen to separate one detector mistake from the others:
- runs of exactly four at the lowest and at the highest position, which catch an off-by-one in the window positions;
- runs of three, which a threshold set too low would wrongly count;
- full-ones bytes, which give the maximum count of 64;
- all-miss arrays, which give a count of 0.

Running the tests back to back shows that the count restarts on each run. Sentinel bytes placed around the window and around the result address show any stray read or write. A `start` pulse in the middle of a run checks that the block ignores it.

// File: rtl/ocr_pkg.sv
package ocr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_WRITE = 2'd3
  } ocr_state_t;
endpackage

// File: rtl/ocr_run_detect.sv
module ocr_run_detect #(
  parameter int DATA_W  = 8,
  parameter int RUN_MIN = 4
) (
  input  logic [DATA_W-1:0] byte_i,
  output logic              hit_o
);
  localparam int NPOS = DATA_W - RUN_MIN + 1;
  logic [NPOS-1:0] win;

  generate
    for (genvar p = 0; p < NPOS; p++) begin : g_win
      assign win[p] = &byte_i[p +: RUN_MIN];
    end
  endgenerate

  assign hit_o = |win;
endmodule

// File: rtl/ocr_scan_ctrl.sv
module ocr_scan_ctrl
  import ocr_pkg::*;
#(
  parameter int LEN   = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output ocr_state_t       state_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN - 1);
  ocr_state_t state;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_READ;
          idx   <= '0;
        end
        ST_READ: begin
          idx <= idx + 1'b1;
          if (idx == LAST) state <= ST_DRAIN;
        end
        ST_DRAIN: state <= ST_WRITE;
        ST_WRITE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state;
  assign idx_o   = idx;
endmodule

// File: rtl/ocr_tally.sv
module ocr_tally #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             rd_issue,
  input  logic             hit,
  output logic [CNT_W-1:0] count_o
);
  logic pend;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      cnt  <= '0;
    end else begin
      pend <= rd_issue;
      if (clear)            cnt <= '0;
      else if (pend && hit) cnt <= cnt + 1'b1;
    end
  end

  assign count_o = cnt;
endmodule

// File: rtl/ones_run_counter.sv
module ones_run_counter
  import ocr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int BASE     = 32,
  parameter int LEN      = 64,
  parameter int RES_ADDR = 5,
  parameter int RUN_MIN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam int CNT_W = $clog2(LEN + 1);

  ocr_state_t       state;
  logic [IDX_W-1:0] idx;
  logic             hit;
  logic [CNT_W-1:0] count;
  logic             done_q;
  logic             accept;

  assign accept = (state == ST_IDLE) && start;

  ocr_scan_ctrl #(.LEN(LEN), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .state_o(state), .idx_o(idx)
  );

  ocr_run_detect #(.DATA_W(DATA_W), .RUN_MIN(RUN_MIN)) u_det (
    .byte_i(mem_rdata), .hit_o(hit)
  );

  ocr_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .rd_issue(state == ST_READ), .hit(hit), .count_o(count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= (state == ST_WRITE);
  end

  always_comb begin
    mem_rd_en = (state == ST_READ);
    mem_wr_en = (state == ST_WRITE);
    mem_wdata = DATA_W'(count);
    if (state == ST_WRITE) mem_addr = ADDR_W'(RES_ADDR);
    else                   mem_addr = ADDR_W'(BASE) + ADDR_W'(idx);
  end

  assign busy = (state != ST_IDLE);
  assign done = done_q;
endmodule

// File: rtl/ones_run_counter_chk.sv
module ones_run_counter_chk #(
  parameter int ADDR_W   = 8,
  parameter int BASE     = 32,
  parameter int LEN      = 64,
  parameter int RES_ADDR = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_en,
  input logic              mem_wr_en
);
  assert_one_port_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  assert_read_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (int'(mem_addr) >= BASE && int'(mem_addr) < BASE + LEN));

  assert_read_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  assert_write_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (int'(mem_addr) == RES_ADDR));

  assert_done_follows_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (done && !busy));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_during_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> busy);
endmodule

bind ones_run_counter ones_run_counter_chk #(
  .ADDR_W(ADDR_W), .BASE(BASE), .LEN(LEN), .RES_ADDR(RES_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en)
);

// File: tb/sim_ones_run_counter.sv
`timescale 1ns/1ps
module sim_ones_run_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, mem_rd_en, mem_wr_en;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0] mem [256];

  int tests = 0, fails = 0, cyc = 0;
  int nreads = 0, nwrites = 0, rd_bad = 0, wr_bad = 0, both = 0;
  int next_rd = 32;

  always #4 clk = ~clk;

  ones_run_counter u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // RAM model: one access per cycle, read data one cycle later
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mem_rd_en && mem_wr_en) both <= both + 1;
    if (rst_n && mem_wr_en) begin
      mem[mem_addr] <= mem_wdata;
      nwrites <= nwrites + 1;
      if (mem_addr != 8'd5) wr_bad <= wr_bad + 1;
    end
    if (rst_n && mem_rd_en) begin
      mem_rdata <= mem[mem_addr];
      nreads <= nreads + 1;
      if (int'(mem_addr) != next_rd) rd_bad <= rd_bad + 1;
      next_rd <= int'(mem_addr) + 1;
    end
  end

  always @(negedge clk) if (cyc > 150000) begin
    fails = fails + 1;
    $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    for (int i = 0; i < 256; i++) mem[i] = 8'h5A;
    for (int i = 0; i < 64; i++) mem[32 + i] = (i < 22) ? a : (i < 43) ? b : c;
  endtask

  // start a run; returns edges to done (-1 if none); optional mid-run start
  task automatic run(input bit poke, output int lat);
    nreads = 0; nwrites = 0; rd_bad = 0; wr_bad = 0; next_rd = 32;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    lat = -1;
    for (int n = 1; n <= 200; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (poke && n == 20) start = 1'b1;
      if (poke && n == 21) start = 1'b0;
      if (done) begin lat = n; break; end
    end
    @(negedge clk);
    check("R7 done one cycle", int'(done), 0);
  endtask

  // vector: {byte band A, band B, band C, expected count}
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {8'h19, 8'hBD, 8'hE7, 8'd21},
    {8'hFF, 8'h00, 8'h00, 8'd22},
    {8'h7D, 8'hB3, 8'hA2, 8'd22},
    {8'hEE, 8'h0F, 8'hF0, 8'd42},
    {8'hFF, 8'hFF, 8'hFF, 8'd64},
    {8'h00, 8'hEE, 8'h77, 8'd0},
    {8'h1E, 8'h3C, 8'h78, 8'd64},
    {8'hE7, 8'h1E, 8'hEE, 8'd21}
  };

  initial begin
    int lat;
    mem_rdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 rd_en in reset", int'(mem_rd_en), 0);
    check("R1 wr_en in reset", int'(mem_wr_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'({busy, done, mem_rd_en, mem_wr_en}), 0);

    for (int v = 0; v < NV; v++) begin
      fill(VEC[v][31:24], VEC[v][23:16], VEC[v][15:8]);
      mem[5] = 8'hC3;
      run(1'b0, lat);
      check("R3 R4 count", int'(mem[5]), int'(VEC[v][7:0]));
      check("R7 latency", lat, 66);
      check("R2 read count", nreads, 64);
      check("R2 read order", rd_bad, 0);
      check("R6 single write", nwrites, 1);
      check("R6 write addr", wr_bad, 0);
      check("R5 no overlap", both, 0);
      check("R6 sentinels", int'({mem[4], mem[6], mem[31], mem[96]}),
            int'({8'h5A, 8'h5A, 8'h5A, 8'h5A}));
    end

    // start pulse mid-run is ignored
    fill(8'hFF, 8'h19, 8'h7D);
    run(1'b1, lat);
    check("R8 count with mid-run start", int'(mem[5]), 43);
    check("R8 latency with mid-run start", lat, 66);
    check("R8 reads with mid-run start", nreads, 64);
    check("R8 idle after run", int'(busy), 0);

    // single hit at window ends; count restarts from a prior full run
    fill(8'h00, 8'h00, 8'h00);
    mem[32] = 8'hF0; mem[95] = 8'h0F; mem[31] = 8'hFF; mem[96] = 8'hFF;
    run(1'b0, lat);
    check("R4 edge bytes only", int'(mem[5]), 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule